// File: doc/BRIEF.md
# Interrupt Vector Address Formatter

This block produces the bytes that an eight-level interrupt controller places on the processor data bus while an interrupt is being acknowledged. It keeps a programmed 16-bit routine base and, for the level that won arbitration, merges the level number into that base to form either a full routine address or a compact vector number. The acknowledge sequencer tells it which byte of the sequence is being read, and the block answers with one registered byte and a drive enable.

There are two processor modes. In byte-wide mode the acknowledge sequence has three bytes: a subroutine-call opcode, then the low half of the routine address, then the high half. The level is placed in the low address bits, and the 4-byte or 8-byte interval setting decides how far it is shifted. In word-wide mode only one byte carries information: a vector number made of the five upper base bits and the three level bits. In that mode the interval setting has no effect.

Priority resolution and cascade handling are done elsewhere. This block only formats the bytes.

Top module: `irq_vec_fmt`

## Requirements
- R1: After reset, the output byte is 0x00, the drive enable is low and the stored base is 0x0000. A later third-byte read in byte-wide mode therefore returns 0x00.
- R2: When the byte-select code is 0 (idle), the next cycle shows a low drive enable and an output byte of 0x00. Whenever the drive enable is low, the output byte is 0x00.
- R3: In byte-wide mode (`mode16` = 0), select code 1 (first byte) yields the call opcode 0xCD with the drive enable high.
- R4: In byte-wide mode with `intv4` = 1 (4-byte interval), select code 2 yields the low address byte. Its bits 1:0 are zero, bits 4:2 are the level, and bits 7:5 are base bits 7:5. Base bits 4:0 have no effect.
- R5: In byte-wide mode with `intv4` = 0 (8-byte interval), select code 2 yields the low address byte. Its bits 2:0 are zero, bits 5:3 are the level, and bits 7:6 are base bits 7:6. Base bits 5:0 have no effect.
- R6: In byte-wide mode, select code 3 (third byte) yields base bits 15:8 for either interval.
- R7: In word-wide mode (`mode16` = 1), select code 2 yields a vector byte. Its bits 7:3 are base bits 15:11 and bits 2:0 are the level. Base bits 10:0 and `intv4` have no effect.
- R8: In word-wide mode, select codes 1 and 3 yield 0x00 with the drive enable low.
- R9: Every output is registered. The byte for a select code shows up after the next rising clock edge and holds until the edge after that.
- R10: The base is loaded from `base_wdata` on a clock edge where `base_we` is high, and it is used from the following cycle. While `base_we` is low, `base_wdata` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load strobe for the routine base |
| base_wdata | input | 16 | Routine base value to load |
| mode16 | input | 1 | 1 = word-wide vector format, 0 = byte-wide call sequence |
| intv4 | input | 1 | 1 = 4-byte routine interval, 0 = 8-byte interval |
| level | input | 3 | Interrupt level that won arbitration |
| byte_sel | input | 2 | Acknowledge byte select: 0 idle, 1 first, 2 second, 3 third |
| data_out | output | 8 | Byte for the data bus, zero when not driven |
| data_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 16-bit routine address and a 3-bit level. With those defaults every level, both intervals and both processor modes can be reached with exact byte values. The table loads bases with different patterns in the bits the current mode ignores, so a wrong shift or a leaked ignored bit changes the observed byte. Directed steps then cover the reset contents, the one-cycle latency and the hold after it, and a base write that is presented without its load strobe.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_BYTE1 = 2'd1,
        SEL_BYTE2 = 2'd2,
        SEL_BYTE3 = 2'd3
    } ack_sel_e;

    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    localparam int SHIFT_INTV4 = 2;
    localparam int SHIFT_INTV8 = 3;

endpackage

// File: rtl/irq_vec_base_reg.sv
module irq_vec_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q
);

    logic [ADDR_W-1:0] base_d;

    always_comb begin
        base_d = base_q;
        if (we) begin
            base_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

endmodule

// File: rtl/irq_vec_addr_gen.sv
module irq_vec_addr_gen
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LVL_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LVL_W-1:0]  level,
    input  logic              intv4,
    output logic [ADDR_W-1:0] addr
);

    localparam int LO4_W = LVL_W + SHIFT_INTV4;
    localparam int LO8_W = LVL_W + SHIFT_INTV8;

    logic [LO4_W-1:0] low4;
    logic [LO8_W-1:0] low8;

    always_comb begin
        low4 = {level, {SHIFT_INTV4{1'b0}}};
        low8 = {level, {SHIFT_INTV8{1'b0}}};
        addr = base;
        if (intv4) begin
            addr[LO4_W-1:0] = low4;
        end else begin
            addr[LO8_W-1:0] = low8;
        end
    end

endmodule

// File: rtl/irq_vec_vector_gen.sv
module irq_vec_vector_gen #(
    parameter int BYTE_W = 8,
    parameter int LVL_W  = 3
) (
    input  logic [BYTE_W-LVL_W-1:0] base_hi,
    input  logic [LVL_W-1:0]        level,
    output logic [BYTE_W-1:0]       vec
);

    always_comb begin
        vec = {base_hi, level};
    end

endmodule

// File: rtl/irq_vec_byte_mux.sv
module irq_vec_byte_mux
    import irq_vec_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [1:0]          byte_sel,
    input  logic                mode16,
    input  logic [2*BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0]   vec,
    output logic [BYTE_W-1:0]   byte_o,
    output logic                oe_o
);

    ack_sel_e sel;

    always_comb begin
        sel    = ack_sel_e'(byte_sel);
        byte_o = '0;
        oe_o   = 1'b0;
        if (mode16) begin
            if (sel == SEL_BYTE2) begin
                byte_o = vec;
                oe_o   = 1'b1;
            end
        end else begin
            unique case (sel)
                SEL_BYTE1: begin
                    byte_o = BYTE_W'(CALL_OPCODE);
                    oe_o   = 1'b1;
                end
                SEL_BYTE2: begin
                    byte_o = addr[BYTE_W-1:0];
                    oe_o   = 1'b1;
                end
                SEL_BYTE3: begin
                    byte_o = addr[2*BYTE_W-1:BYTE_W];
                    oe_o   = 1'b1;
                end
                default: begin
                    byte_o = '0;
                    oe_o   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_vec_fmt.sv
module irq_vec_fmt #(
    parameter int BYTE_W = 8,
    parameter int LVL_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                base_we,
    input  logic [2*BYTE_W-1:0] base_wdata,
    input  logic                mode16,
    input  logic                intv4,
    input  logic [LVL_W-1:0]    level,
    input  logic [1:0]          byte_sel,
    output logic [BYTE_W-1:0]   data_out,
    output logic                data_oe
);

    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int VHI_W   = BYTE_W - LVL_W;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              oe;
    } out_t;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] vec;
    logic [BYTE_W-1:0] mux_byte;
    logic              mux_oe;
    out_t              out_d;
    out_t              out_q;

    irq_vec_base_reg #(
        .ADDR_W (ADDR_W)
    ) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (base_we),
        .wdata  (base_wdata),
        .base_q (base_q)
    );

    irq_vec_addr_gen #(
        .ADDR_W (ADDR_W),
        .LVL_W  (LVL_W)
    ) u_addr (
        .base  (base_q),
        .level (level),
        .intv4 (intv4),
        .addr  (addr)
    );

    irq_vec_vector_gen #(
        .BYTE_W (BYTE_W),
        .LVL_W  (LVL_W)
    ) u_vec (
        .base_hi (base_q[ADDR_W-1 -: VHI_W]),
        .level   (level),
        .vec     (vec)
    );

    irq_vec_byte_mux #(
        .BYTE_W (BYTE_W)
    ) u_mux (
        .byte_sel (byte_sel),
        .mode16   (mode16),
        .addr     (addr),
        .vec      (vec),
        .byte_o   (mux_byte),
        .oe_o     (mux_oe)
    );

    always_comb begin
        out_d.oe   = mux_oe;
        out_d.data = mux_oe ? mux_byte : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_out = out_q.data;
    assign data_oe  = out_q.oe;

endmodule

// File: rtl/irq_vec_fmt_chk.sv
module irq_vec_fmt_chk #(
    parameter int BYTE_W = 8,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode16,
    input logic              intv4,
    input logic [LVL_W-1:0]  level,
    input logic [1:0]        byte_sel,
    input logic [BYTE_W-1:0] data_out,
    input logic              data_oe
);

    // R2: an idle select leaves the bus undriven on the next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_sel == 2'd0) |=> (!data_oe && data_out == '0));

    // R2: undriven bus always carries zero
    p_zero_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    // R3: first byte in byte-wide mode is the call opcode
    p_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16 && byte_sel == 2'd1) |=> (data_oe && data_out == 8'hCD));

    // R4: 4-byte interval places the level above two zero bits
    p_low4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16 && intv4 && byte_sel == 2'd2)
        |=> (data_out[LVL_W+1:0] == {$past(level), 2'b00}));

    // R5: 8-byte interval places the level above three zero bits
    p_low8_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16 && !intv4 && byte_sel == 2'd2)
        |=> (data_out[LVL_W+2:0] == {$past(level), 3'b000}));

    // R7: word-wide vector carries the level in its low bits
    p_vec_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && byte_sel == 2'd2)
        |=> (data_oe && data_out[LVL_W-1:0] == $past(level)));

    // R8: word-wide mode keeps the bus off for the other select codes
    p_vec_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && (byte_sel == 2'd1 || byte_sel == 2'd3)) |=> !data_oe);

endmodule

bind irq_vec_fmt irq_vec_fmt_chk #(
    .BYTE_W (BYTE_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode16   (mode16),
    .intv4    (intv4),
    .level    (level),
    .byte_sel (byte_sel),
    .data_out (data_out),
    .data_oe  (data_oe)
);

// File: tb/irq_vec_fmt_bench.sv
`timescale 1ns/1ps
module irq_vec_fmt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [15:0] base_wdata = '0;
    logic        mode16 = 1'b0;
    logic        intv4 = 1'b0;
    logic [2:0]  level = '0;
    logic [1:0]  byte_sel = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_vec_fmt u_irq_vec_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .mode16     (mode16),
        .intv4      (intv4),
        .level      (level),
        .byte_sel   (byte_sel),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    // entry: req[35:32] mode16[31] intv4[30] sel[29:28] level[27:25]
    //        base[24:9] exp_oe[8] exp_byte[7:0]
    localparam int NV = 18;
    localparam logic [35:0] VEC [NV] = '{
        {4'd3,  1'b0, 1'b1, 2'd1, 3'd5, 16'hA5F3, 1'b1, 8'hCD}, // R3
        {4'd4,  1'b0, 1'b1, 2'd2, 3'd5, 16'hA5F3, 1'b1, 8'hF4}, // R4
        {4'd5,  1'b0, 1'b0, 2'd2, 3'd5, 16'hA5F3, 1'b1, 8'hE8}, // R5
        {4'd6,  1'b0, 1'b1, 2'd3, 3'd2, 16'hA5F3, 1'b1, 8'hA5}, // R6
        {4'd6,  1'b0, 1'b0, 2'd3, 3'd7, 16'hA5F3, 1'b1, 8'hA5}, // R6
        {4'd7,  1'b1, 1'b1, 2'd2, 3'd6, 16'hA5F3, 1'b1, 8'hA6}, // R7
        {4'd7,  1'b1, 1'b0, 2'd2, 3'd6, 16'hA5F3, 1'b1, 8'hA6}, // R7
        {4'd8,  1'b1, 1'b1, 2'd1, 3'd3, 16'hA5F3, 1'b0, 8'h00}, // R8
        {4'd8,  1'b1, 1'b0, 2'd3, 3'd3, 16'hA5F3, 1'b0, 8'h00}, // R8
        {4'd2,  1'b0, 1'b1, 2'd0, 3'd4, 16'hA5F3, 1'b0, 8'h00}, // R2
        {4'd4,  1'b0, 1'b1, 2'd2, 3'd0, 16'h1234, 1'b1, 8'h20}, // R4
        {4'd5,  1'b0, 1'b0, 2'd2, 3'd7, 16'h1234, 1'b1, 8'h38}, // R5
        {4'd4,  1'b0, 1'b1, 2'd2, 3'd7, 16'h1234, 1'b1, 8'h3C}, // R4
        {4'd7,  1'b1, 1'b1, 2'd2, 3'd7, 16'h1234, 1'b1, 8'h17}, // R7
        {4'd3,  1'b0, 1'b0, 2'd1, 3'd0, 16'h1234, 1'b1, 8'hCD}, // R3
        {4'd7,  1'b1, 1'b0, 2'd2, 3'd6, 16'hA7FF, 1'b1, 8'hA6}, // R7
        {4'd4,  1'b0, 1'b1, 2'd2, 3'd0, 16'h001F, 1'b1, 8'h00}, // R4
        {4'd5,  1'b0, 1'b0, 2'd2, 3'd1, 16'h003F, 1'b1, 8'h08}  // R5
    };

    task automatic check(input string req, input logic exp_oe, input logic [7:0] exp_b);
        checks++;
        if (data_oe !== exp_oe || data_out !== exp_b) begin
            fails++;
            $display("FAIL %s: got oe=%b byte=%02h, expected oe=%b byte=%02h",
                     req, data_oe, data_out, exp_oe, exp_b);
        end
    endtask

    task automatic load_base(input logic [15:0] b);
        @(negedge clk);
        byte_sel   = 2'd0;
        base_wdata = b;
        base_we    = 1'b1;
        @(negedge clk);
        base_we    = 1'b0;
    endtask

    task automatic apply(input logic m16, input logic i4, input logic [1:0] s, input logic [2:0] l);
        @(negedge clk);
        mode16   = m16;
        intv4    = i4;
        byte_sel = s;
        level    = l;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: base cleared by reset
        apply(1'b0, 1'b1, 2'd3, 3'd0);
        check("R1", 1'b1, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [35:0] e;
            e = VEC[i];
            load_base(e[24:9]);
            apply(e[31], e[30], e[29:28], e[27:25]);
            check($sformatf("R%0d", e[35:32]), e[8], e[7:0]);
        end

        // R10: write without strobe is ignored
        load_base(16'hA5F3);
        @(negedge clk);
        base_wdata = 16'h5A00;
        apply(1'b0, 1'b0, 2'd3, 3'd0);
        check("R10", 1'b1, 8'hA5);

        // R10: write with strobe takes effect next cycle
        load_base(16'h5A00);
        apply(1'b0, 1'b0, 2'd3, 3'd0);
        check("R10", 1'b1, 8'h5A);

        // R9: latency and hold
        apply(1'b0, 1'b1, 2'd0, 3'd0);
        @(negedge clk);
        byte_sel = 2'd1;
        #1;
        check("R9", 1'b0, 8'h00);
        @(posedge clk);
        #1;
        check("R9", 1'b1, 8'hCD);
        @(negedge clk);
        byte_sel = 2'd0;
        #1;
        check("R9", 1'b1, 8'hCD);
        @(posedge clk);
        #1;
        check("R2", 1'b0, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got hung run, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule